// File: doc/BRIEF.md
# Masked Vector Element Shift Unit

The unit executes one shift instruction on a whole vector register. It decodes a 32-bit instruction word into one of three shift operations (logical left, logical right, arithmetic right) and one of three sources for the shift amount. The amount can come from the same-index element of a second vector, from one scalar value shared by every element, or from a 5-bit immediate in the instruction. The element width is chosen at run time as 8, 16, 32 or 64 bits. Every element of the VLEN-bit source register is shifted in parallel, and the packed result is stored in a result register.

Writes are governed by three things. The first is a per-element mask, unless the instruction turns masking off. The second is an active length: positions at or past it are cleared. The third is that a zero active length makes the whole operation a no-op. The caller presents the previous destination contents on `dst_old`. One cycle after `start` the unit raises `done` for one cycle and holds the new destination on `result`. A word that does not decode raises `illegal` and leaves the destination unchanged.

Control is a two-state machine. In ST_IDLE the unit waits. A `start` moves it to ST_DONE and loads the result register in the same edge. From ST_DONE it goes back to ST_IDLE when `start` is low. A new `start` keeps it in ST_DONE, so instructions can be issued back to back.

Top module: `vsh_unit`

## Requirements
- R1: An instruction is legal only when all three fields hold one of the listed values. Bits [6:0] must be 7'b1010111. Bits [31:26] must be 6'b100101 (left logical), 6'b101000 (right logical) or 6'b101001 (right arithmetic). Bits [14:12] must be 3'b000 (vector amount), 3'b100 (scalar amount) or 3'b011 (immediate amount). Any other word sets `illegal`, and `result` takes the value of `dst_old`.
- R2: `sew` codes 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit elements. Only the low `sew`+3 bits of each shift amount are used, and higher amount bits have no effect.
- R3: Left logical shifts the element left and fills with zeros. Bits shifted past the element width are lost.
- R4: Right logical treats the element as unsigned and fills with zeros.
- R5: Right arithmetic treats the element as signed and fills with copies of its sign bit.
- R6: With the vector amount source, element i takes its amount from element i of `src_amt`. With the scalar source, every element uses `scalar`. With the immediate source, every element uses bits [19:15] of the instruction, zero-extended.
- R7: Bit 25 of the instruction enables masking. When bit 25 is 0, an active element whose `mask_bits[i]` is 0 keeps its `dst_old` value. When bit 25 is 1, every active element is written.
- R8: Elements whose index is `vl` or more, up to VLEN/SEW-1, are zero in `result`.
- R9: When `vl` is 0, `result` equals `dst_old`: neither active nor tail elements change.
- R10: `done` is a one-cycle pulse in the cycle after `start`. `result` and `illegal` change only in that cycle. All three are 0 after reset.
- R11: Elements are packed little-endian: element i occupies bits [i*SEW +: SEW] of every vector port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Execute the presented instruction this cycle |
| instr | input | 32 | Instruction word |
| sew | input | 2 | Element width code |
| vl | input | $clog2(VLEN/8+1) | Active element count |
| mask_bits | input | VLEN/8 | Per-element enable, bit i for element i |
| src_val | input | VLEN | Vector being shifted |
| src_amt | input | VLEN | Per-element shift amounts (vector source) |
| scalar | input | XLEN | Scalar shift amount |
| dst_old | input | VLEN | Previous destination contents |
| result | output | VLEN | New destination contents |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last instruction did not decode |

## Verification
The assertions assume three things about the inputs. `vl` never exceeds VLEN/SEW for the width in use. `start` is low throughout reset. `dst_old` is steady in the cycle `start` is sampled. The stimulus keeps within these limits in two ways. It sweeps `vl` only from 0 to the element count of each width, and it changes inputs only at the falling clock edge. The sweep covers every width, operation, amount source and mask-enable setting. Amounts carry random high bits, so masking to the element width is exercised throughout.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
    typedef enum logic [1:0] {
        SH_LEFT      = 2'd0,
        SH_RIGHT_LOG = 2'd1,
        SH_RIGHT_ARI = 2'd2
    } shift_op_e;

    typedef enum logic [1:0] {
        AMT_VECTOR = 2'd0,
        AMT_SCALAR = 2'd1,
        AMT_IMM    = 2'd2
    } amt_src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

    localparam logic [6:0] MAJOR_VEC  = 7'b1010111;
    localparam logic [5:0] F6_LEFT    = 6'b100101;
    localparam logic [5:0] F6_RLOG    = 6'b101000;
    localparam logic [5:0] F6_RARI    = 6'b101001;
    localparam logic [2:0] F3_VECTOR  = 3'b000;
    localparam logic [2:0] F3_SCALAR  = 3'b100;
    localparam logic [2:0] F3_IMM     = 3'b011;
endpackage

// File: rtl/vsh_decode.sv
module vsh_decode
    import vsh_pkg::*;
(
    input  logic [31:0] instr,
    output shift_op_e   op,
    output amt_src_e    src,
    output logic        unmasked,
    output logic [4:0]  imm,
    output logic        legal
);
    logic op_ok;
    logic src_ok;
    logic unused_fields;

    assign unused_fields = ^{instr[24:20], instr[11:7]};
    assign unmasked      = instr[25];
    assign imm           = instr[19:15];

    always_comb begin
        op    = SH_LEFT;
        op_ok = 1'b1;
        case (instr[31:26])
            F6_LEFT: op = SH_LEFT;
            F6_RLOG: op = SH_RIGHT_LOG;
            F6_RARI: op = SH_RIGHT_ARI;
            default: op_ok = 1'b0;
        endcase
    end

    always_comb begin
        src    = AMT_VECTOR;
        src_ok = 1'b1;
        case (instr[14:12])
            F3_VECTOR: src = AMT_VECTOR;
            F3_SCALAR: src = AMT_SCALAR;
            F3_IMM:    src = AMT_IMM;
            default:   src_ok = 1'b0;
        endcase
    end

    assign legal = op_ok && src_ok && (instr[6:0] == MAJOR_VEC);
endmodule

// File: rtl/vsh_elem.sv
module vsh_elem
    import vsh_pkg::*;
#(
    parameter int W = 8,
    localparam int SH = $clog2(W)
) (
    input  shift_op_e       op,
    input  logic [W-1:0]    val,
    input  logic [SH-1:0]   amt,
    output logic [W-1:0]    res
);
    always_comb begin
        unique case (op)
            SH_LEFT:      res = val << amt;
            SH_RIGHT_LOG: res = val >> amt;
            SH_RIGHT_ARI: res = W'($signed(val) >>> amt);
            default:      res = '0;
        endcase
    end
endmodule

// File: rtl/vsh_lanes.sv
module vsh_lanes
    import vsh_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int XLEN = 64,
    parameter int W    = 8,
    localparam int N    = VLEN / W,
    localparam int MAXE = VLEN / 8,
    localparam int VL_W = $clog2(MAXE + 1),
    localparam int SH   = $clog2(W)
) (
    input  shift_op_e        op,
    input  amt_src_e         src,
    input  logic             unmasked,
    input  logic [4:0]       imm,
    input  logic [VL_W-1:0]  vl,
    input  logic [MAXE-1:0]  mask_bits,
    input  logic [VLEN-1:0]  src_val,
    input  logic [VLEN-1:0]  src_amt,
    input  logic [XLEN-1:0]  scalar,
    input  logic [VLEN-1:0]  dst_old,
    output logic [VLEN-1:0]  vec_out
);
    logic [5:0] imm_ext;
    logic       unused_bits;

    assign imm_ext     = {1'b0, imm};
    assign unused_bits = ^{src_amt, scalar, mask_bits, imm_ext};

    for (genvar e = 0; e < N; e++) begin : g_elem
        logic [SH-1:0] amt;
        logic [W-1:0]  shifted;
        logic          active;
        logic          enabled;

        always_comb begin
            unique case (src)
                AMT_VECTOR: amt = src_amt[e*W +: SH];
                AMT_SCALAR: amt = scalar[SH-1:0];
                AMT_IMM:    amt = imm_ext[SH-1:0];
                default:    amt = '0;
            endcase
        end

        vsh_elem #(.W(W)) elem_i (
            .op  (op),
            .val (src_val[e*W +: W]),
            .amt (amt),
            .res (shifted)
        );

        assign active  = (int'(vl) > e);
        assign enabled = unmasked || mask_bits[e];

        always_comb begin
            if (!active)       vec_out[e*W +: W] = '0;
            else if (enabled)  vec_out[e*W +: W] = shifted;
            else               vec_out[e*W +: W] = dst_old[e*W +: W];
        end
    end
endmodule

// File: rtl/vsh_unit.sv
module vsh_unit
    import vsh_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int XLEN = 64,
    localparam int MAXE = VLEN / 8,
    localparam int VL_W = $clog2(MAXE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      instr,
    input  logic [1:0]       sew,
    input  logic [VL_W-1:0]  vl,
    input  logic [MAXE-1:0]  mask_bits,
    input  logic [VLEN-1:0]  src_val,
    input  logic [VLEN-1:0]  src_amt,
    input  logic [XLEN-1:0]  scalar,
    input  logic [VLEN-1:0]  dst_old,
    output logic [VLEN-1:0]  result,
    output logic             done,
    output logic             illegal
);
    shift_op_e        op;
    amt_src_e         src;
    logic             unmasked;
    logic [4:0]       imm;
    logic             legal;
    logic [VLEN-1:0]  by_width [4];
    logic [VLEN-1:0]  next_vec;
    state_e           state_q;
    state_e           state_d;

    vsh_decode dec_i (
        .instr    (instr),
        .op       (op),
        .src      (src),
        .unmasked (unmasked),
        .imm      (imm),
        .legal    (legal)
    );

    for (genvar k = 0; k < 4; k++) begin : g_width
        vsh_lanes #(.VLEN(VLEN), .XLEN(XLEN), .W(8 << k)) lanes_i (
            .op        (op),
            .src       (src),
            .unmasked  (unmasked),
            .imm       (imm),
            .vl        (vl),
            .mask_bits (mask_bits),
            .src_val   (src_val),
            .src_amt   (src_amt),
            .scalar    (scalar),
            .dst_old   (dst_old),
            .vec_out   (by_width[k])
        );
    end

    assign next_vec = (!legal || vl == '0) ? dst_old : by_width[sew];

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            result  <= '0;
            illegal <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                result  <= next_vec;
                illegal <= !legal;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: done = 1'b0;
            ST_DONE: done = 1'b1;
            default: done = 1'b0;
        endcase
    end
endmodule

// File: rtl/vsh_chk.sv
module vsh_chk #(
    parameter int VLEN = 128,
    localparam int MAXE = VLEN / 8,
    localparam int VL_W = $clog2(MAXE + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       sew,
    input logic [VL_W-1:0]  vl,
    input logic [VLEN-1:0]  dst_old,
    input logic [VLEN-1:0]  result,
    input logic             done,
    input logic             illegal
);
    assert_done_follows_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    assert_done_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

    assert_illegal_keeps_dst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (result == $past(dst_old)));

    assert_zero_vl_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && vl == '0) |=> (result == $past(dst_old)));

    assert_byte_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && sew == 2'd0 && vl != '0) |=>
            (illegal || ((result >> (8 * int'($past(vl)))) == '0)));
endmodule

bind vsh_unit vsh_chk #(.VLEN(VLEN)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sew     (sew),
    .vl      (vl),
    .dst_old (dst_old),
    .result  (result),
    .done    (done),
    .illegal (illegal)
);

// File: tb/vsh_unit_tb_top.sv
module vsh_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN = 128;
    localparam int XLEN = 64;
    localparam int MAXE = VLEN / 8;
    localparam int VL_W = $clog2(MAXE + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [31:0]      instr = '0;
    logic [1:0]       sew = '0;
    logic [VL_W-1:0]  vl = '0;
    logic [MAXE-1:0]  mask_bits = '0;
    logic [VLEN-1:0]  src_val = '0;
    logic [VLEN-1:0]  src_amt = '0;
    logic [XLEN-1:0]  scalar = '0;
    logic [VLEN-1:0]  dst_old = '0;
    logic [VLEN-1:0]  result;
    logic             done;
    logic             illegal;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vsh_unit #(.VLEN(VLEN), .XLEN(XLEN)) dut_i (.*);

    function automatic logic [5:0] f6_of(int opc);
        case (opc)
            0: return 6'b100101;
            1: return 6'b101000;
            default: return 6'b101001;
        endcase
    endfunction

    function automatic logic [2:0] f3_of(int form);
        case (form)
            0: return 3'b000;
            1: return 3'b100;
            default: return 3'b011;
        endcase
    endfunction

    function automatic logic [31:0] mk(logic [5:0] f6, logic vmb, logic [2:0] f3, logic [4:0] im);
        return {f6, vmb, 5'd2, im, f3, 5'd1, 7'b1010111};
    endfunction

    function automatic logic [VLEN-1:0] model(int sw, int opc, int form, logic vmb, int len,
            logic [MAXE-1:0] mk_b, logic [VLEN-1:0] v2, logic [VLEN-1:0] v1,
            logic [XLEN-1:0] sc, logic [4:0] im, logic [VLEN-1:0] old);
        int w = 8 << sw;
        int n = VLEN / w;
        logic [63:0] lm = (64'd1 << w) - 64'd1;
        logic [VLEN-1:0] acc = '0;
        if (len == 0) return old;
        for (int i = 0; i < n; i++) begin
            logic [63:0] v = 64'(v2 >> (i * w)) & lm;
            logic [63:0] o = 64'(old >> (i * w)) & lm;
            logic [63:0] a;
            logic [63:0] r;
            logic signed [63:0] sv;
            if (form == 0) a = 64'(v1 >> (i * w)) & 64'(w - 1);
            else if (form == 1) a = sc & 64'(w - 1);
            else a = {59'd0, im} & 64'(w - 1);
            if (opc == 0) r = (v << a) & lm;
            else if (opc == 1) r = v >> a;
            else begin
                sv = v[w-1] ? $signed(v | ~lm) : $signed(v);
                r = 64'(sv >>> a) & lm;
            end
            if (i >= len) r = '0;
            else if (!vmb && !mk_b[i]) r = o;
            acc = acc | (VLEN'(r) << (i * w));
        end
        return acc;
    endfunction

    task automatic check(string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] exp;
        repeat (3) @(negedge clk);
        check("R10 reset result", result, '0);
        check("R10 reset done", VLEN'(done), '0);
        check("R10 reset illegal", VLEN'(illegal), '0);
        rst_n = 1'b1;

        for (int sw = 0; sw < 4; sw++) begin
            for (int opc = 0; opc < 3; opc++) begin
                for (int form = 0; form < 3; form++) begin
                    for (int vmi = 0; vmi < 2; vmi++) begin
                        for (int len = 1; len <= (VLEN / (8 << sw)); len++) begin
                            logic [4:0] im = 5'($urandom);
                            @(negedge clk);
                            sew = 2'(sw);
                            vl = VL_W'(len);
                            mask_bits = MAXE'($urandom);
                            src_val = {$urandom, $urandom, $urandom, $urandom};
                            src_amt = {$urandom, $urandom, $urandom, $urandom};
                            scalar = {$urandom, $urandom};
                            dst_old = {$urandom, $urandom, $urandom, $urandom};
                            instr = mk(f6_of(opc), 1'(vmi), f3_of(form), im);
                            exp = model(sw, opc, form, 1'(vmi), len, mask_bits, src_val,
                                        src_amt, scalar, im, dst_old);
                            issue();
                            if (opc == 0)
                                check("R3 R2 R6 R7 R8 R11 left", result, exp);
                            else if (opc == 1)
                                check("R4 R2 R6 R7 R8 R11 right logical", result, exp);
                            else
                                check("R5 R2 R6 R7 R8 R11 right arithmetic", result, exp);
                            check("R10 done pulse", VLEN'(done), VLEN'(1));
                            check("R1 legal word", VLEN'(illegal), '0);
                        end
                    end
                end
            end
        end

        @(negedge clk);
        check("R10 done falls", VLEN'(done), '0);

        // R5 fixed case: 64-bit element 0x8000..0 >> 63 (imm 31 -> 31), scalar 63 with high bits
        @(negedge clk);
        sew = 2'd3; vl = VL_W'(2);
        src_val = {64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000};
        scalar = 64'hFFFF_FFFF_FFFF_FFFF;
        dst_old = '1;
        instr = mk(6'b101001, 1'b1, 3'b100, 5'd0);
        issue();
        check("R5 R2 sign fill", result, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});

        // R6 immediate zero-extended: 31 on 32-bit right logical
        @(negedge clk);
        sew = 2'd2; vl = VL_W'(4);
        src_val = {4{32'h8000_0000}};
        instr = mk(6'b101000, 1'b1, 3'b011, 5'd31);
        issue();
        check("R6 imm zero extend", result, {4{32'h0000_0001}});

        // R9 zero length
        @(negedge clk);
        vl = '0; dst_old = {4{32'hA5A5_5A5A}};
        instr = mk(6'b100101, 1'b1, 3'b000, 5'd0);
        issue();
        check("R9 zero vl", result, {4{32'hA5A5_5A5A}});

        // R1 illegal words
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            vl = VL_W'(4);
            dst_old = {$urandom, $urandom, $urandom, $urandom};
            exp = dst_old;
            case (k)
                0: instr = mk(6'b000000, 1'b1, 3'b000, 5'd1);
                1: instr = mk(6'b100101, 1'b1, 3'b010, 5'd1);
                default: instr = mk(6'b100101, 1'b1, 3'b000, 5'd1) ^ 32'h1;
            endcase
            issue();
            check("R1 illegal flag", VLEN'(illegal), VLEN'(1));
            check("R1 illegal keeps dst", result, exp);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule